// File: doc/BRIEF.md
# Periodic SPI Read Requester

This block sits on the application side of a read-only SPI interface and asks it for a fresh sample at a fixed rate. It derives the serial clock from the system clock. Each rising edge of that serial clock advances a refresh counter and a small handshake sequencer. When the refresh period has elapsed, the block raises a read request. It then holds the request until the interface reports data-ready.

On the serial-clock edge where data-ready is seen with the request still high, the block copies the 16-bit word into its LED output register and drops the request. Dropping the request is the acknowledge. The block then waits for data-ready to fall before it starts timing the next period, so two reads never overlap. The block also turns the active-high board reset button into the active-low reset that the interface expects.

The logic runs on the system clock. It advances only on a one-cycle strobe that marks each rising edge of the divided serial clock, so its behaviour is that of logic clocked by the serial clock.

Top module: `spi_poll_seq`

## Requirements
- R1: While `btn_rst` is high, `rd_req` is 0, `led` is all zeros and `sclk` is 0 after the next system clock edge. A reset in the middle of a request returns the block to the start of a refresh period.
- R2: `iface_rst_n` is the combinational inverse of `btn_rst`.
- R3: After reset is released, `sclk` first rises on the HALF_DIV-th system clock edge. It then toggles every HALF_DIV system clocks, with a default of 25.
- R4: After reset, `rd_req` rises on exactly the REFRESH_PERIOD-th rising edge of `sclk`, with a default of 40000, and not earlier.
- R5: Once raised, `rd_req` stays high on every `sclk` rising edge where `data_ready` is low. It falls on the first `sclk` rising edge where `data_ready` is high.
- R6: `led` loads `data_word` only on the `sclk` rising edge where `data_ready` is high while `rd_req` is high. A change of `data_word` at any other time leaves `led` unchanged.
- R7: After `rd_req` falls, no new request is raised while `data_ready` stays high. The next `rd_req` rises on the REFRESH_PERIOD-th `sclk` rising edge after the edge where `data_ready` is first seen low.
- R8: When `data_ready` is high while no request is pending, it changes neither `led` nor `rd_req`, and it does not shift the timing of the next request.
- R9: `led` holds the full word bit for bit (`led[i]` = `data_word[i]`). A sample placed in bits 12..5 with zeros around it therefore shows in the middle of the LEDs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| btn_rst | input | 1 | Board reset button, active high |
| data_ready | input | 1 | Data-ready flag from the SPI read interface |
| data_word | input | 16 | Word returned by the SPI read interface |
| sclk | output | 1 | Divided serial clock |
| iface_rst_n | output | 1 | Active-low reset for the SPI read interface |
| rd_req | output | 1 | Read request to the interface; falling is the acknowledge |
| led | output | 16 | Last captured word |

## Verification
On every cycle, the assertions check these rules: the serial clock toggles only at the divider limit, the refresh count stays in range and restarts when the block leaves the wait phase, the request rises only after the count expires and falls only after data-ready was seen, and the LED register changes only on a capture strobe. The exact number of clocks per half period, the exact serial edge on which each request appears, and which data word ends up on the LEDs can be shown only by the bench scenarios. Those scenarios hold data-ready for varying lengths, change the data word outside the capture edge, and apply a reset in the middle of a request.

// File: rtl/spi_poll_pkg.sv
// Shared types for the periodic SPI read requester.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package spi_poll_pkg;

    // Handshake phases of the requester.
    typedef enum logic [1:0] {
        PH_WAIT    = 2'd0,   // timing the refresh period
        PH_REQ     = 2'd1,   // request high, waiting for data-ready
        PH_RELEASE = 2'd2    // request dropped, waiting for data-ready to fall
    } poll_phase_t;

endpackage

// File: rtl/sclk_divider.sv
// Serial clock divider: toggles sclk every HALF_DIV system clocks and
// emits a one-cycle strobe on the system clock edge where sclk rises.
// Assumes HALF_DIV >= 2; reset is synchronous and active low.
module sclk_divider #(
    parameter int HALF_DIV = 25
) (
    input  logic clk,
    input  logic rst_n,
    output logic sclk,
    output logic rise
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LIMIT = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    // Count system clocks and flip sclk at the half-period limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (cnt == LIMIT) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Strobe marks the edge on which sclk goes from low to high.
    assign rise = (cnt == LIMIT) && !sclk;

    // R3: sclk changes only when the counter sat at its limit.
    a_r3_toggle_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sclk) && $past(rst_n)) |-> ($past(cnt) == LIMIT));

    // R3: the rise strobe is followed by sclk high.
    a_r3_rise_then_high: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> sclk);
endmodule

// File: rtl/refresh_timer.sv
// Refresh timer: while run is high, counts serial-clock strobes and
// pulses expire on the REFRESH-th one; clears whenever run is low.
// Assumes REFRESH >= 1; reset is synchronous and active low.
module refresh_timer #(
    parameter int REFRESH = 40000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    output logic expire
);
    localparam int CW = (REFRESH > 1) ? $clog2(REFRESH) : 1;
    localparam logic [CW-1:0] LAST = CW'(REFRESH - 1);

    logic [CW-1:0] cnt;

    // Advance on each strobe during the wait phase, restart otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign expire = run && tick && (cnt == LAST);

    // R4: the count never runs past the last period.
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R7: leaving the wait phase restarts the count from zero.
    a_r7_restart_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));
endmodule

// File: rtl/poll_handshake.sv
// Handshake sequencer: raises the read request on timer expiry, captures
// the word and drops the request when data-ready is seen, then waits for
// data-ready to fall. Advances only on serial-clock strobes.
// Assumes data_ready and data_word are stable around each strobe.
module poll_handshake
    import spi_poll_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              expire,
    input  logic              data_ready,
    input  logic [DATA_W-1:0] data_word,
    output logic              run,
    output logic              rd_req,
    output logic [DATA_W-1:0] led
);
    poll_phase_t phase;

    // Four-phase handshake, stepped on each serial-clock rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_WAIT;
            rd_req <= 1'b0;
            led    <= '0;
        end else if (tick) begin
            case (phase)
                PH_WAIT: if (expire) begin
                    rd_req <= 1'b1;
                    phase  <= PH_REQ;
                end
                PH_REQ: if (data_ready) begin
                    led    <= data_word;
                    rd_req <= 1'b0;
                    phase  <= PH_RELEASE;
                end
                PH_RELEASE: if (!data_ready) phase <= PH_WAIT;
                default: phase <= PH_WAIT;
            endcase
        end
    end

    // Timer runs only in the wait phase.
    assign run = (phase == PH_WAIT);

    // R4: a request rises only after the timer expired.
    a_r4_req_after_expire: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_req) && $past(rst_n)) |-> $past(expire));

    // R5: the request falls only on a strobe with data-ready high.
    a_r5_drop_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_req) && $past(rst_n)) |-> ($past(data_ready) && $past(tick)));

    // R6: the LED register changes only on a capture strobe.
    a_r6_led_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(led) && $past(rst_n)) |-> $past(tick && data_ready && rd_req));

    // R7: no request while waiting for data-ready to fall.
    a_r7_quiet_release: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RELEASE) |-> !rd_req);
endmodule

// File: rtl/spi_poll_seq.sv
// Periodic SPI read requester top: serial clock divider, refresh timer and
// handshake sequencer. Also inverts the board reset for the interface.
// Assumes btn_rst is already synchronous to clk.
module spi_poll_seq #(
    parameter int DATA_W         = 16,
    parameter int HALF_DIV       = 25,
    parameter int REFRESH_PERIOD = 40000
) (
    input  logic              clk,
    input  logic              btn_rst,
    input  logic              data_ready,
    input  logic [DATA_W-1:0] data_word,
    output logic              sclk,
    output logic              iface_rst_n,
    output logic              rd_req,
    output logic [DATA_W-1:0] led
);
    logic rst_n;
    logic tick;
    logic run;
    logic expire;

    // Active-high button becomes the active-low reset used everywhere.
    assign rst_n       = ~btn_rst;
    assign iface_rst_n = rst_n;

    sclk_divider #(.HALF_DIV(HALF_DIV)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .sclk (sclk),
        .rise (tick)
    );

    refresh_timer #(.REFRESH(REFRESH_PERIOD)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .run   (run),
        .expire(expire)
    );

    poll_handshake #(.DATA_W(DATA_W)) u_hs (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .expire    (expire),
        .data_ready(data_ready),
        .data_word (data_word),
        .run       (run),
        .rd_req    (rd_req),
        .led       (led)
    );
endmodule

// File: tb/spi_poll_seq_bench.sv
module spi_poll_seq_bench;
    localparam int REF = 4;
    localparam int HD  = 25;

    // {word, low rises before ready, high rises after capture}
    localparam logic [31:0] VEC [0:3] = '{
        {16'h1FE0, 8'd0, 8'd0},
        {16'hFFFF, 8'd3, 8'd2},
        {16'h0000, 8'd1, 8'd4},
        {16'hA5C3, 8'd5, 8'd1}
    };

    logic        clk = 1'b0;
    logic        btn_rst = 1'b1;
    logic        data_ready = 1'b0;
    logic [15:0] data_word = 16'h0;
    logic        sclk, iface_rst_n, rd_req;
    logic [15:0] led;
    int          tests = 0;
    int          fails = 0;

    always #10 clk = ~clk;

    spi_poll_seq #(.DATA_W(16), .HALF_DIV(HD), .REFRESH_PERIOD(REF)) u_spi_poll_seq (
        .clk(clk), .btn_rst(btn_rst), .data_ready(data_ready), .data_word(data_word),
        .sclk(sclk), .iface_rst_n(iface_rst_n), .rd_req(rd_req), .led(led)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance to the first negedge after sclk rises.
    task automatic rise();
        logic p;
        bit   seen;
        p = sclk;
        seen = 1'b0;
        while (!seen) begin
            @(negedge clk);
            seen = !p && sclk;
            p = sclk;
        end
    endtask

    task automatic rises_to_req(output int n);
        n = 0;
        while (!rd_req && n < 40) begin
            rise();
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n;
        logic [15:0] prev;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(rd_req == 1'b0, "R1", rd_req, 0);
        check(led == 16'h0, "R1", led, 0);
        check(sclk == 1'b0, "R1", sclk, 0);
        check(iface_rst_n == 1'b0, "R2", iface_rst_n, 0);

        btn_rst = 1'b0;
        #1 check(iface_rst_n == 1'b1, "R2", iface_rst_n, 1);
        // R3: first rise after HD clocks, then HD per half period
        n = 0;
        while (!sclk && n < 200) begin @(negedge clk); n++; end
        check(n == HD, "R3", n, HD);
        check(rd_req == 1'b0, "R4", rd_req, 0);
        n = 0;
        while (sclk && n < 200) begin @(negedge clk); n++; end
        check(n == HD, "R3", n, HD);
        // R8: data_ready while idle is ignored
        data_ready = 1'b1;
        data_word  = 16'hBEEF;
        rise();
        check(led == 16'h0, "R8", led, 0);
        check(rd_req == 1'b0, "R8", rd_req, 0);
        rise();
        check(rd_req == 1'b0, "R4", rd_req, 0);
        data_ready = 1'b0;
        rise();
        check(rd_req == 1'b1, "R4", rd_req, 1);
        check(led == 16'h0, "R8", led, 0);

        prev = 16'h0;
        for (int i = 0; i < 4; i++) begin
            logic [15:0] w;
            w = VEC[i][31:16];
            for (int k = 0; k < int'(VEC[i][15:8]); k++) begin
                data_word = 16'hDEAD;
                rise();
                check(rd_req == 1'b1, "R5", rd_req, 1);
                check(led == prev, "R6", led, prev);
            end
            data_word  = w;
            data_ready = 1'b1;
            rise();
            check(led == w, "R9", led, w);
            check(rd_req == 1'b0, "R5", rd_req, 0);
            data_word = ~w;
            for (int k = 0; k < int'(VEC[i][7:0]); k++) begin
                rise();
                check(rd_req == 1'b0, "R7", rd_req, 0);
                check(led == w, "R6", led, w);
            end
            data_ready = 1'b0;
            rises_to_req(n);
            check(n == REF + 1, "R7", n, REF + 1);
            prev = w;
        end

        // R1: reset in the middle of a request
        btn_rst = 1'b1;
        #1 check(iface_rst_n == 1'b0, "R2", iface_rst_n, 0);
        repeat (3) @(negedge clk);
        check(rd_req == 1'b0, "R1", rd_req, 0);
        check(led == 16'h0, "R1", led, 0);
        btn_rst = 1'b0;
        #1 check(iface_rst_n == 1'b1, "R2", iface_rst_n, 1);
        rises_to_req(n);
        check(n == REF, "R1", n, REF);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule